// File: doc/BRIEF.md
# Lockable SMRAM Access Guard

This block sits on the memory-controller side. For each memory request from a CPU or a DMA agent, it decides whether the request may reach the system-management RAM. Two fixed address windows are guarded: a legacy window and a high window. A third window, the extended segment, takes its base and size from two registers of its own. It does not depend on any top-of-memory value, so changing such a value elsewhere cannot move the guarded area.

A small control register switches the windows on. It also grants or withholds access from outside system-management mode, and it can close the legacy window to system-management requests. A sticky lock bit freezes the control register and both segment registers until reset.

A separate range register, with a base, a mask and a valid bit, applies to CPU requests only. It can be written only by a writer that is in system-management mode. A CPU request that hits this range from outside that mode is refused, whatever the control register says. A refused write is dropped, and a refused read is answered with an all-ones constant. The verdict for a request is registered and appears on the cycle after the request.

Top module: `smram_guard`

## Requirements
- R1: After reset the control register, the segment size and the range-register valid bit are all zero. Every request presented with `req_valid` high produces `rsp_valid` high exactly one clock later. No response appears without a request.
- R2: Control bit 3 (enable) switches on the legacy window 0x000A0000–0x000BFFFF, the high window 0xFEDA0000–0xFEDBFFFF and the segment window. While enable is 0, or for an address outside every window, the request is allowed.
- R3: With enable set and open clear, a request to a window is allowed only if it comes from a CPU in system-management mode. A refused write gives `rsp_drop_wr`; a refused read gives `rsp_fixed`.
- R4: Control bit 6 (open) lets requests from outside system-management mode, DMA included, into the windows.
- R5: Control bit 5 (closed) refuses system-management requests to the legacy window only. The high window and the segment window still admit them.
- R6: Control bit 4 (lock) can only be set. It clears only on reset. A control write that sets lock forces open to 0. While lock is set, writes to the control register, the segment base and the segment size have no effect.
- R7: Select 1 loads the segment base from data bits [31:20]. Select 2 loads the segment size, in 1 MiB units, from bits [3:0]. The window covers [base, base+size). A size of 0 turns the window off.
- R8: A request with `req_dma`=1 is treated as outside system-management mode whatever `req_smm` says. The range register never applies to it.
- R9: Select 3 loads the range base from bits [31:12]. Select 4 loads the range mask from bits [31:12] and the valid bit from bit 0. A valid range refuses CPU requests from outside system-management mode. This takes precedence over open. A CPU request in that mode passes the range and is then judged by the window rules.
- R10: Writes to selects 3 and 4 take effect only when `cfg_smm` is 1, and they are not affected by lock.
- R11: A configuration write on a clock edge affects only requests presented after that edge. A request presented in the same cycle as the write is judged by the old configuration.
- R12: When `rsp_valid` is high, exactly one of `rsp_allow`, `rsp_drop_wr`, `rsp_fixed` is 1. When it is low, all three are 0. `rsp_fixed_data` is all ones exactly when `rsp_fixed` is 1, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Requester claims system-management mode |
| req_dma | input | 1 | Request comes from a DMA agent |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0 control, 1 segment base, 2 segment size, 3 range base, 4 range mask |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_smm | input | 1 | Configuration writer is in system-management mode |
| rsp_valid | output | 1 | Verdict valid (one cycle after request) |
| rsp_allow | output | 1 | Request may proceed |
| rsp_drop_wr | output | 1 | Refused write, to be discarded |
| rsp_fixed | output | 1 | Refused read, answer with constant |
| rsp_fixed_data | output | 32 | All-ones read data when `rsp_fixed` is set |

## Verification
Two functions can meet in one cycle. The first case is a configuration write presented together with a request: the bench drives a control write that clears open in the same cycle as a request from outside system-management mode to the legacy window. It expects an allow for that request and a fixed-data refusal for the next one. The second case is a single control write that sets lock and open together; it is judged by a refusal on the next request from outside system-management mode. A scoreboard queue pairs each request with its expected verdict and compares the verdicts as they appear.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL      = 3'd0,
        SEL_TSEG_BASE = 3'd1,
        SEL_TSEG_SIZE = 3'd2,
        SEL_RR_BASE   = 3'd3,
        SEL_RR_MASK   = 3'd4
    } cfg_sel_e;

    // control register field positions
    localparam int CTRL_EN_BIT   = 3;
    localparam int CTRL_LOCK_BIT = 4;
    localparam int CTRL_CLS_BIT  = 5;
    localparam int CTRL_OPEN_BIT = 6;

    // range-mask word: valid flag position
    localparam int RR_VALID_BIT  = 0;

    // fixed windows: index 0 is the legacy window (subject to "closed")
    localparam int NUM_FIXED_WIN = 2;

    typedef struct packed {
        logic allow;
        logic drop_wr;
        logic fixed;
    } verdict_t;

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TSEG_SHIFT = 20,
    parameter int TSEG_SZ_W  = 4,
    parameter int RR_SHIFT   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_sel,
    input  logic [ADDR_W-1:0]          wr_data,
    input  logic                       wr_smm,
    output logic                       cfg_en,
    output logic                       cfg_lock,
    output logic                       cfg_cls,
    output logic                       cfg_open,
    output logic [ADDR_W-TSEG_SHIFT-1:0] tseg_base,
    output logic [TSEG_SZ_W-1:0]       tseg_size,
    output logic [ADDR_W-RR_SHIFT-1:0] rr_base,
    output logic [ADDR_W-RR_SHIFT-1:0] rr_mask,
    output logic                       rr_valid
);

    localparam int TB_W = ADDR_W - TSEG_SHIFT;
    localparam int RB_W = ADDR_W - RR_SHIFT;

    typedef struct packed {
        logic              en;
        logic              lock;
        logic              cls;
        logic              open;
        logic [TB_W-1:0]   tb;
        logic [TSEG_SZ_W-1:0] ts;
        logic [RB_W-1:0]   rb;
        logic [RB_W-1:0]   rm;
        logic              rv;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    if (!st_q.lock) begin
                        st_d.en   = wr_data[CTRL_EN_BIT];
                        st_d.cls  = wr_data[CTRL_CLS_BIT];
                        st_d.lock = wr_data[CTRL_LOCK_BIT];
                        st_d.open = wr_data[CTRL_OPEN_BIT] & ~wr_data[CTRL_LOCK_BIT];
                    end
                end
                SEL_TSEG_BASE: begin
                    if (!st_q.lock) st_d.tb = wr_data[ADDR_W-1:TSEG_SHIFT];
                end
                SEL_TSEG_SIZE: begin
                    if (!st_q.lock) st_d.ts = wr_data[TSEG_SZ_W-1:0];
                end
                SEL_RR_BASE: begin
                    if (wr_smm) st_d.rb = wr_data[ADDR_W-1:RR_SHIFT];
                end
                SEL_RR_MASK: begin
                    if (wr_smm) begin
                        st_d.rm = wr_data[ADDR_W-1:RR_SHIFT];
                        st_d.rv = wr_data[RR_VALID_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_en    = st_q.en;
    assign cfg_lock  = st_q.lock;
    assign cfg_cls   = st_q.cls;
    assign cfg_open  = st_q.open;
    assign tseg_base = st_q.tb;
    assign tseg_size = st_q.ts;
    assign rr_base   = st_q.rb;
    assign rr_mask   = st_q.rm;
    assign rr_valid  = st_q.rv;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R6
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable({st_q.en, st_q.cls, st_q.open, st_q.tb, st_q.ts})); // R6
    AST_LOCK_CLEARS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lock) |-> !st_q.open); // R6
    AST_RR_SMM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_smm) |=> $stable({st_q.rb, st_q.rm, st_q.rv})); // R10

endmodule

// File: rtl/smram_win_cmp.sv
module smram_win_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W:0]   hi_x,
    output logic              hit
);

    always_comb begin
        hit = en && ({1'b0, addr} >= {1'b0, lo}) && ({1'b0, addr} < hi_x);
    end

endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int TSEG_SHIFT = 20,
    parameter int TSEG_SZ_W  = 4,
    parameter int RR_SHIFT   = 12,
    parameter logic [ADDR_W-1:0] LEG_BASE  = 32'h000A_0000,
    parameter logic [ADDR_W-1:0] LEG_SIZE  = 32'h0002_0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0] HIGH_SIZE = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic              req_dma,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cfg_smm,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_drop_wr,
    output logic              rsp_fixed,
    output logic [DATA_W-1:0] rsp_fixed_data
);

    localparam int TB_W = ADDR_W - TSEG_SHIFT;
    localparam int RB_W = ADDR_W - RR_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_BASE [NUM_FIXED_WIN] = '{LEG_BASE, HIGH_BASE};
    localparam logic [ADDR_W-1:0] WIN_SIZE [NUM_FIXED_WIN] = '{LEG_SIZE, HIGH_SIZE};

    typedef struct packed {
        logic     valid;
        verdict_t v;
    } rsp_t;

    logic                 cfg_en, cfg_lock, cfg_cls, cfg_open, rr_valid;
    logic [TB_W-1:0]      tseg_base;
    logic [TSEG_SZ_W-1:0] tseg_size;
    logic [RB_W-1:0]      rr_base, rr_mask;

    smram_cfg_regs #(
        .ADDR_W(ADDR_W), .TSEG_SHIFT(TSEG_SHIFT),
        .TSEG_SZ_W(TSEG_SZ_W), .RR_SHIFT(RR_SHIFT)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_sel), .wr_data(cfg_wdata), .wr_smm(cfg_smm),
        .cfg_en(cfg_en), .cfg_lock(cfg_lock), .cfg_cls(cfg_cls), .cfg_open(cfg_open),
        .tseg_base(tseg_base), .tseg_size(tseg_size),
        .rr_base(rr_base), .rr_mask(rr_mask), .rr_valid(rr_valid)
    );

    logic unused_lock;
    assign unused_lock = cfg_lock;

    // fixed windows
    logic [NUM_FIXED_WIN-1:0] fixed_hit;
    for (genvar g = 0; g < NUM_FIXED_WIN; g++) begin : g_fixed_win
        smram_win_cmp #(.ADDR_W(ADDR_W)) win_i (
            .en(cfg_en),
            .addr(req_addr),
            .lo(WIN_BASE[g]),
            .hi_x({1'b0, WIN_BASE[g]} + {1'b0, WIN_SIZE[g]}),
            .hit(fixed_hit[g])
        );
    end

    // extended segment window from its own base/size registers
    logic [ADDR_W-1:0] tseg_lo;
    logic [ADDR_W:0]   tseg_hi;
    logic              tseg_hit;

    always_comb begin
        tseg_lo = {tseg_base, {TSEG_SHIFT{1'b0}}};
        tseg_hi = {1'b0, tseg_lo} + ((ADDR_W+1)'(tseg_size) << TSEG_SHIFT);
    end

    smram_win_cmp #(.ADDR_W(ADDR_W)) tseg_i (
        .en(cfg_en && (tseg_size != '0)),
        .addr(req_addr),
        .lo(tseg_lo),
        .hi_x(tseg_hi),
        .hit(tseg_hit)
    );

    // CPU-side range register
    logic rr_hit;
    always_comb begin
        rr_hit = !req_dma && rr_valid &&
                 ((req_addr[ADDR_W-1:RR_SHIFT] & rr_mask) == (rr_base & rr_mask));
    end

    // verdict
    rsp_t rsp_d, rsp_q;
    logic in_smm, prot_hit, grant;

    always_comb begin
        in_smm   = req_smm && !req_dma;
        prot_hit = (|fixed_hit) || tseg_hit;
        if (!prot_hit)   grant = 1'b1;
        else if (in_smm) grant = !(cfg_cls && fixed_hit[0]);
        else             grant = cfg_open;
        if (rr_hit && !in_smm) grant = 1'b0;

        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid     = 1'b1;
            rsp_d.v.allow   = grant;
            rsp_d.v.drop_wr = !grant && req_write;
            rsp_d.v.fixed   = !grant && !req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_allow      = rsp_q.v.allow;
    assign rsp_drop_wr    = rsp_q.v.drop_wr;
    assign rsp_fixed      = rsp_q.v.fixed;
    assign rsp_fixed_data = {DATA_W{rsp_q.v.fixed}};

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_allow, rsp_drop_wr, rsp_fixed}) == 1)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_allow, rsp_drop_wr, rsp_fixed} == 3'b000)); // R12
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_DROP_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_drop_wr); // R3
    AST_DMA_NOT_SMM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dma && prot_hit && !cfg_open) |=> !rsp_allow); // R8
    AST_RR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dma && !req_smm && rr_hit) |=> !rsp_allow); // R9

endmodule

// File: tb/smram_guard_tb.sv
`timescale 1ns/1ps
module smram_guard_tb_top;

    localparam logic [2:0] EXP_ALLOW = 3'b100;
    localparam logic [2:0] EXP_DROP  = 3'b010;
    localparam logic [2:0] EXP_FIXED = 3'b001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_smm = 1'b0, req_dma = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_smm = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_drop_wr, rsp_fixed;
    logic [31:0] rsp_fixed_data;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    logic [2:0] q_exp[$];
    string      q_tag[$];

    always #2.5 clk = ~clk;

    smram_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_smm(req_smm), .req_dma(req_dma),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_smm(cfg_smm),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_drop_wr(rsp_drop_wr),
        .rsp_fixed(rsp_fixed), .rsp_fixed_data(rsp_fixed_data)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare each verdict with the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (q_exp.size() == 0) begin
                    check("R1 unexpected response", 36'h1, 36'h0);
                end else begin
                    logic [2:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(t, {rsp_allow, rsp_drop_wr, rsp_fixed, 1'b0, rsp_fixed_data},
                             {e, 1'b0, {32{e[0]}}});
                end
            end
        end
    end

    // driver tasks
    task automatic rq(input logic [31:0] a, input logic wr, input logic smm,
                      input logic dma, input logic [2:0] e, input string tag);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm; req_dma = dma;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_smm = 1'b0; req_dma = 1'b0;
    endtask

    task automatic wcfg(input logic [2:0] sel, input logic [31:0] d, input logic smm);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_smm = smm;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_smm = 1'b0;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, nothing reported
        check("R1 reset outputs", {32'h0, rsp_valid, rsp_allow, rsp_drop_wr, rsp_fixed},
                                  {32'h0, 4'b0000});
        check("R12 reset fixed data", {4'h0, rsp_fixed_data}, 36'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled windows are open to all
        rq(32'h000A_8000, 0, 0, 0, EXP_ALLOW, "R2 disabled legacy read");
        wcfg(3'd0, 32'h08, 0);
        rq(32'h000A_8000, 0, 0, 0, EXP_FIXED, "R3 non-SMM legacy read");
        rq(32'hFEDA_1000, 1, 0, 0, EXP_DROP,  "R3 non-SMM high write");
        rq(32'h000A_8000, 1, 1, 0, EXP_ALLOW, "R3 SMM legacy write");
        rq(32'h0010_0000, 0, 0, 0, EXP_ALLOW, "R2 outside windows");
        rq(32'h000C_0000, 0, 0, 0, EXP_ALLOW, "R2 legacy end boundary");
        rq(32'h000B_FFFC, 0, 0, 0, EXP_FIXED, "R2 legacy last word");
        rq(32'hFEDC_0000, 1, 0, 0, EXP_ALLOW, "R2 high end boundary");

        // R7: segment window
        rq(32'h7F00_0000, 0, 0, 0, EXP_ALLOW, "R7 size zero disables");
        wcfg(3'd1, 32'h7F00_0000, 0);
        wcfg(3'd2, 32'h0000_0002, 0);
        rq(32'h7F1F_FFFC, 0, 0, 0, EXP_FIXED, "R7 segment last word");
        rq(32'h7F20_0000, 0, 0, 0, EXP_ALLOW, "R7 segment end");
        rq(32'h7EFF_FFFC, 0, 0, 0, EXP_ALLOW, "R7 below segment");
        rq(32'h7F00_0000, 1, 1, 0, EXP_ALLOW, "R7 SMM segment write");

        // R8: DMA never counts as SMM
        rq(32'h000A_8000, 1, 1, 1, EXP_DROP,  "R8 DMA write with smm flag");
        rq(32'h7F00_0100, 0, 1, 1, EXP_FIXED, "R8 DMA segment read");

        // R5: closed bit
        wcfg(3'd0, 32'h28, 0);
        rq(32'h000A_8000, 0, 1, 0, EXP_FIXED, "R5 closed legacy SMM read");
        rq(32'hFEDA_1000, 0, 1, 0, EXP_ALLOW, "R5 closed high SMM read");
        rq(32'h7F00_0000, 1, 1, 0, EXP_ALLOW, "R5 closed segment SMM write");

        // R4: open bit
        wcfg(3'd0, 32'h48, 0);
        rq(32'h000A_8000, 1, 0, 0, EXP_ALLOW, "R4 open non-SMM write");
        rq(32'h7F00_0040, 0, 0, 1, EXP_ALLOW, "R4 open DMA read");

        // R10: range writes outside SMM ignored
        wcfg(3'd3, 32'h1000_0000, 0);
        wcfg(3'd4, 32'hFFFF_F001, 0);
        rq(32'h1000_0010, 0, 0, 0, EXP_ALLOW, "R10 non-SMM range write ignored");
        // R9: range register active
        wcfg(3'd3, 32'h1000_0000, 1);
        wcfg(3'd4, 32'hFFFF_F001, 1);
        rq(32'h1000_0010, 0, 0, 0, EXP_FIXED, "R9 range non-SMM read");
        rq(32'h1000_0FF0, 1, 0, 0, EXP_DROP,  "R9 range non-SMM write");
        rq(32'h1000_1000, 0, 0, 0, EXP_ALLOW, "R9 range end");
        rq(32'h1000_0010, 0, 1, 0, EXP_ALLOW, "R9 range SMM read");
        rq(32'h1000_0010, 1, 0, 1, EXP_ALLOW, "R8 DMA bypasses range");
        wcfg(3'd3, 32'h000A_8000, 1);
        rq(32'h000A_8010, 0, 0, 0, EXP_FIXED, "R9 range beats open");
        rq(32'h000A_9000, 0, 0, 0, EXP_ALLOW, "R4 open outside range");
        rq(32'h000A_8010, 1, 1, 0, EXP_ALLOW, "R9 SMM passes range");

        // R11: config write and request in the same cycle
        cfg_wr_en = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h08;
        rq(32'h000A_9000, 0, 0, 0, EXP_ALLOW, "R11 same-cycle old config");
        cfg_wr_en = 1'b0;
        rq(32'h000A_9000, 0, 0, 0, EXP_FIXED, "R11 next cycle new config");

        // R6: lock set together with open
        wcfg(3'd0, 32'h58, 0);
        rq(32'h000A_9000, 0, 0, 0, EXP_FIXED, "R6 lock forces open low");
        wcfg(3'd0, 32'h48, 0);
        rq(32'h000A_9000, 1, 0, 0, EXP_DROP,  "R6 locked open write ignored");
        wcfg(3'd0, 32'h00, 0);
        rq(32'hFEDA_1000, 0, 0, 0, EXP_FIXED, "R6 locked enable held");
        wcfg(3'd0, 32'h28, 0);
        rq(32'h000A_9000, 0, 1, 0, EXP_ALLOW, "R6 locked closed write ignored");
        wcfg(3'd2, 32'h0, 0);
        wcfg(3'd1, 32'h2000_0000, 0);
        rq(32'h7F10_0000, 0, 0, 0, EXP_FIXED, "R6 locked segment kept");
        rq(32'h2000_0000, 0, 0, 0, EXP_ALLOW, "R6 segment base not moved");

        // R10: range register writable under lock
        wcfg(3'd3, 32'h3000_0000, 1);
        rq(32'h3000_0020, 0, 0, 0, EXP_FIXED, "R10 range moved under lock");
        wcfg(3'd4, 32'hFFFF_F000, 1);
        rq(32'h3000_0020, 0, 0, 0, EXP_ALLOW, "R10 range invalidated");

        repeat (3) @(negedge clk);
        check("R1 all responses seen", {4'h0, 32'(q_exp.size())}, 36'h0);
        done = 1'b1;
        finish_run();
    end

endmodule